// File: doc/BRIEF.md
# Mask-Driven GPIO Controller

This block is a memory-mapped general-purpose I/O controller for up to twenty pins. It hangs off a plain single-cycle register bus: a byte address, a write strobe, 64-bit write data and 64-bit read data. Read data is combinational from the address, so a read completes in the cycle its address is presented. Writes take effect at the next rising clock edge.

Software never writes pin output values directly. It writes a bit mask to a set port or to a clear port, and only the pins selected by the mask change. Each pin also has its own 64-bit configuration word, and only bit 0 of that word is implemented, as the output enable. A single shared word returns the synchronized input level of every pin.

The configuration words are 8 bytes apart. The first sixteen pins occupy offsets 0x000 to 0x078. Pins 16 to 19 restart at 0x100. The input word is at 0x080, the set port at 0x088 and the clear port at 0x090. A build parameter `NUM_PINS` selects 20 pins (the default) or 16 pins. With 16 pins, the upper configuration words are unmapped.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pin_out` and `pin_oe` are all zero.
- R2: A write to 0x088 drives `pin_out[n]` high for every n whose write-data bit n is 1. All other outputs keep their value.
- R3: A write to 0x090 drives `pin_out[n]` low for every n whose write-data bit n is 1. All other outputs keep their value.
- R4: For pins 0 to 15, a write to byte offset 8*n loads write-data bit 0 into `pin_oe[n]`. A written value of zero makes the pin an input.
- R5: For pins 16 to 19, the configuration word of pin n is at byte offset 0x100 + 8*(n-16), with the same bit-0 behaviour as R4.
- R6: A read of a configuration word returns the pin's output enable in bit 0 and zero in bits 63:1. Write-data bits 63:1 of a configuration write have no effect.
- R7: A read of 0x080 returns pin n's input level in bit n and zero above the pin count. The level passes through two flops, so a change made before clock edge k is visible after edge k+1 and not after edge k.
- R8: Reads of 0x088, 0x090 and any unmapped or misaligned address return zero. Writes to unmapped or misaligned addresses, and to 0x080, change no output or enable.
- R9: Set and clear mask bits at or above `NUM_PINS` are ignored. They neither wrap onto lower pins nor change any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |

## Verification
The bench targets the address map at its seam. It writes pin 15 at 0x078, pin 16 at 0x100 and pin 19 at 0x118. A decoder that packed the upper pins right after pin 15 would enable the wrong pin, and one that aliased address bits would react to the misaligned 0x004 or to 0x098. Mask writes check that unselected pins keep their values, catching a set or clear port that overwrites instead of merging. A mask with only high bits set checks that nothing wraps onto low pins. The input path is sampled one edge early and one edge on time, exposing a synchronizer with one flop too few or too many. Configuration writes with bit 0 clear and the upper bits set expose a design that keys the enable on a nonzero word instead of bit 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_INPUT   = 32'h080;
  localparam int unsigned OFS_SET     = 32'h088;
  localparam int unsigned OFS_CLEAR   = 32'h090;
  localparam int unsigned OFS_HI_BASE = 32'h100;
  localparam int unsigned LO_PINS     = 16;
  localparam int unsigned STRIDE      = 8;

  // Byte offset of a pin's configuration word; the map restarts after pin 15.
  function automatic int unsigned cfg_offset(input int unsigned pin);
    if (pin < LO_PINS) return STRIDE * pin;
    return OFS_HI_BASE + STRIDE * (pin - LO_PINS);
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int NUM_PINS = 20,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_PINS-1:0] hit_cfg,
  output logic              hit_input,
  output logic              hit_set,
  output logic              hit_clear,
  output logic              hit_any
);
  import gpio_pkg::*;

  localparam logic [ADDR_W-1:0] A_INPUT = ADDR_W'(OFS_INPUT);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(cfg_offset(p));
    assign hit_cfg[p] = (addr == A_CFG);
  end

  assign hit_input = (addr == A_INPUT);
  assign hit_set   = (addr == A_SET);
  assign hit_clear = (addr == A_CLEAR);
  assign hit_any   = hit_input | hit_set | hit_clear | (|hit_cfg);

  // At most one register answers any address (R8: no aliasing)
  assert_onehot_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_cfg, hit_input, hit_set, hit_clear}));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw;
      stage2_q <= stage1_q;
    end
  end

  assign synced = stage2_q;

  // Check latency only once two edges have passed since reset
  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (!rst_n) settle_q <= '0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (synced == $past(raw, 2)));
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
  parameter int NUM_PINS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_set,
  input  logic                wr_clear,
  input  logic [NUM_PINS-1:0] wr_cfg,
  input  logic [NUM_PINS-1:0] mask,
  input  logic                oe_bit,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] oe_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (wr_set) begin
      out_q <= out_q | mask;
    end else if (wr_clear) begin
      out_q <= out_q & ~mask;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    always_ff @(posedge clk) begin
      if (!rst_n)         oe_q[p] <= 1'b0;
      else if (wr_cfg[p]) oe_q[p] <= oe_bit;
    end
  end

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(mask)) == $past(mask)));
  assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((out_q & $past(mask)) == '0));
  assert_unmasked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set | wr_clear) |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set | wr_clear) |=> $stable(out_q));
  assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg == '0) |=> $stable(oe_q));
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl #(
  parameter int NUM_PINS = 20,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  logic [NUM_PINS-1:0] hit_cfg;
  logic hit_input, hit_set, hit_clear, hit_any;
  logic [NUM_PINS-1:0] in_synced;

  gpio_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .hit_cfg(hit_cfg), .hit_input(hit_input), .hit_set(hit_set),
    .hit_clear(hit_clear), .hit_any(hit_any)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(in_synced)
  );

  gpio_pin_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_set(bus_wr & hit_set),
    .wr_clear(bus_wr & hit_clear),
    .wr_cfg({NUM_PINS{bus_wr}} & hit_cfg),
    .mask(bus_wdata[NUM_PINS-1:0]),
    .oe_bit(bus_wdata[0]),
    .out_q(pin_out),
    .oe_q(pin_oe)
  );

  // Mask bits above the pin count and reserved config bits are dropped
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  always_comb begin
    bus_rdata = '0;
    if (hit_input) bus_rdata[NUM_PINS-1:0] = in_synced;
    if (|(hit_cfg & pin_oe)) bus_rdata[0] = 1'b1;
  end

  assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_any | hit_set | hit_clear) |-> (bus_rdata == '0));
  assert_cfg_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_cfg) |-> (bus_rdata[DATA_W-1:1] == '0));
endmodule

// File: tb/gpio_setclr_ctrl_tb.sv
module gpio_setclr_ctrl_tb;
  localparam int NP = 20;
  localparam int AW = 12;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_setclr_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Vector table: address, write data, expected out, expected oe, requirement
  localparam logic [AW-1:0] V_ADDR [NV] = '{
    12'h088, 12'h088, 12'h090, 12'h000, 12'h078, 12'h100, 12'h118,
    12'h000, 12'h098, 12'h080, 12'h004, 12'h090, 12'h118};
  localparam logic [NP-1:0] V_DATA [NV] = '{
    20'h0000F, 20'hF0000, 20'h00005, 20'h00001, 20'h00003, 20'h00001, 20'h00001,
    20'h00000, 20'hFFFFF, 20'hFFFFF, 20'h00001, 20'hFFFFF, 20'hFFFFE};
  localparam logic [NP-1:0] V_OUT [NV] = '{
    20'h0000F, 20'hF000F, 20'hF000A, 20'hF000A, 20'hF000A, 20'hF000A, 20'hF000A,
    20'hF000A, 20'hF000A, 20'hF000A, 20'hF000A, 20'h00000, 20'h00000};
  localparam logic [NP-1:0] V_OE [NV] = '{
    20'h00000, 20'h00000, 20'h00000, 20'h00001, 20'h08001, 20'h18001, 20'h98001,
    20'h98000, 20'h98000, 20'h98000, 20'h98000, 20'h98000, 20'h18000};
  // R2 R2 R3 R4 R4 R5 R5 R4 R8 R8 R8 R3 R6
  localparam int V_REQ [NV] = '{2, 2, 3, 4, 4, 5, 5, 4, 8, 8, 8, 3, 6};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    check("R1 out in reset", 64'(pin_out), 64'h0);
    check("R1 oe in reset", 64'(pin_oe), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after reset", 64'(pin_out), 64'h0);
    check("R1 oe after reset", 64'(pin_oe), 64'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(V_ADDR[i], 64'(V_DATA[i]));
      check($sformatf("R%0d vec%0d out", V_REQ[i], i), 64'(pin_out), 64'(V_OUT[i]));
      check($sformatf("R%0d vec%0d oe", V_REQ[i], i), 64'(pin_oe), 64'(V_OE[i]));
    end

    // R6: config read-back, bit 0 only
    bus_read(12'h078, rd); check("R6 read pin15 cfg", rd, 64'h1);
    bus_read(12'h100, rd); check("R6 read pin16 cfg", rd, 64'h1);
    bus_read(12'h118, rd); check("R6 read pin19 cfg", rd, 64'h0);
    bus_read(12'h000, rd); check("R6 read pin0 cfg", rd, 64'h0);
    // R8: write-only ports and unmapped addresses read zero
    bus_read(12'h088, rd); check("R8 read set port", rd, 64'h0);
    bus_read(12'h090, rd); check("R8 read clear port", rd, 64'h0);
    bus_read(12'h200, rd); check("R8 read unmapped", rd, 64'h0);
    bus_read(12'h07C, rd); check("R8 read misaligned", rd, 64'h0);

    // R9: high mask bits must not wrap onto low pins
    bus_write(12'h088, 64'hFFFF_FFFF_FFF0_0003);
    check("R9 set high bits ignored", 64'(pin_out), 64'h00003);
    bus_write(12'h090, 64'hFFFF_FFFF_FFF0_0000);
    check("R9 clear high bits ignored", 64'(pin_out), 64'h00003);

    // R7: two-flop input latency
    bus_read(12'h080, rd); check("R7 input idle", rd, 64'h0);
    @(negedge clk); pin_in = 20'hABCDE;
    @(negedge clk); #1 check("R7 input one edge", bus_rdata, 64'h0);
    @(negedge clk); #1 check("R7 input two edges", bus_rdata, 64'hABCDE);
    pin_in = 20'h13579;
    @(negedge clk); @(negedge clk); #1 check("R7 input second pattern", bus_rdata, 64'h13579);

    // R1: reset in the middle of operation
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 out mid reset", 64'(pin_out), 64'h0);
    check("R1 oe mid reset", 64'(pin_oe), 64'h0);
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule